// File: doc/BRIEF.md
# Per-Port Ethernet Statistics Counter Bank

This block keeps the frame and byte statistics of a small multi-port Ethernet switch. Every port owns a 256-byte window of 32-bit registers. The window holds thirty-six 32-bit event counters and three 64-bit byte counters, packed at a 4-byte stride. The MAC side reports each frame event as a one-cycle strobe that has already been decoded. It reports byte totals as a strobe with a length. The block adds these into the matching counter.

Software reads the counters through a word-addressed read port that returns data one cycle after the request. One control register starts a self-timed flush, and its busy bit stays readable while the flush runs. The flush visits one counter word per clock across all ports. A separate enable register gates all counting.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset every counter word reads zero, the busy bit (bit 31 of the control register at 0x0030) reads zero, and the enable bit (bit 0 of the register at 0x0034) reads zero.
- R2: Counter word w of port p is read at address 0x1000 + 0x100*p + 4*w. Event strobe e of port p (input bit p*36+e) maps to a word as follows:
  - e = 0 to 14 map to words 0 to 14.
  - e = 15 and 16 map to words 19 and 20.
  - e = 17 to 28 map to words 21 to 32.
  - e = 29 to 35 map to words 35 to 41.
- R3: While counting is enabled, each cycle in which an event strobe is high adds one to its 32-bit counter, modulo 2^32. Strobes on different ports in the same cycle each count.
- R4: The three byte counters are 64 bits wide. The low word sits at the listed offset and the high word at offset+4.
  - Good receive bytes at offset 0x3C add the receive length when the receive strobe is high and the bad flag is low.
  - Bad receive bytes at 0x44 add the receive length when the receive strobe and the bad flag are both high.
  - Transmit bytes at 0x84 add the transmit length on the transmit strobe.
- R5: A byte add that overflows the low word carries into the high word in the same cycle.
- R6: While the enable bit is zero, event and byte strobes change no counter.
- R7: Writing the control register with bit 31 and bit 24 both set, while no flush is running, starts a flush. A write with only bit 24 set starts nothing.
- R8: Once started, busy reads as one for exactly NUM_PORTS*42 consecutive read cycles and then reads zero. Every counter reads zero afterwards.
- R9: When an increment and the flush hit the same counter word in the same cycle, the word becomes zero.
- R10: Inside a port window, reads of offsets 0xA8 and above return zero. Reads at window addresses of ports at or above NUM_PORTS also return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_PORTS*36 | One-cycle event strobes, 36 per port |
| rx_byte_vld_i | input | NUM_PORTS | Receive byte count valid, per port |
| rx_byte_bad_i | input | NUM_PORTS | Receive frame was bad, per port |
| rx_byte_len_i | input | NUM_PORTS*BYTE_W | Receive byte count, per port |
| tx_byte_vld_i | input | NUM_PORTS | Transmit byte count valid, per port |
| tx_byte_len_i | input | NUM_PORTS*BYTE_W | Transmit byte count, per port |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 16 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 16 | Register read byte address |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |

## Verification
The assertions assume several things about the inputs:
- Event and byte strobes are ordinary one-cycle pulses that may repeat on consecutive cycles.
- Reset stays low until the clock runs.
- Register writes carry plain word addresses.

For these assumptions the flush-wins and step-by-one properties look only at port 0, counter 0. The stimulus drives every input from the falling edge and holds strobes for counted cycles. It writes the control register only at points where the exact busy window can be predicted. One case deliberately holds a strobe high for the whole flush, so that the collision in R9 occurs at a known edge.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_EVT    = 36;
  localparam int NUM_BYTE   = 3;
  localparam int WORDS      = 42;
  localparam int CNT_W      = 32;
  localparam int WIDX_W     = $clog2(WORDS);

  // word slot of event counter e inside a port window
  function automatic int evt_word(input int e);
    if (e < 15)      return e;
    else if (e < 29) return e + 4;
    else             return e + 6;
  endfunction

  // low word slot of byte counter b (0 rx good, 1 rx bad, 2 tx)
  function automatic int byte_lo(input int b);
    if (b == 0)      return 15;
    else if (b == 1) return 17;
    else             return 33;
  endfunction
endpackage

// File: rtl/stat_port_bank.sv
module stat_port_bank
  import stat_pkg::*;
#(
  parameter int BYTE_W = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic [NUM_EVT-1:0]                  evt_i,
  input  logic [NUM_BYTE-1:0]                 byte_vld_i,
  input  logic [NUM_BYTE-1:0][BYTE_W-1:0]     byte_len_i,
  input  logic                                clr_vld_i,
  input  logic [WIDX_W-1:0]                   clr_word_i,
  output logic [NUM_EVT-1:0][CNT_W-1:0]       evt_cnt_o,
  output logic [NUM_BYTE-1:0][2*CNT_W-1:0]    byte_cnt_o
);
  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    localparam int W = evt_word(e);
    logic hit;
    assign hit = clr_vld_i && (int'(clr_word_i) == W);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                evt_cnt_o[e] <= '0;
      else if (hit)               evt_cnt_o[e] <= '0;
      else if (en_i && evt_i[e])  evt_cnt_o[e] <= evt_cnt_o[e] + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BYTE; b++) begin : g_byte
    localparam int WL = byte_lo(b);
    logic [2*CNT_W-1:0] sum;
    logic               hit_lo, hit_hi;
    assign sum    = byte_cnt_o[b] + ((en_i && byte_vld_i[b]) ?
                    {{(2*CNT_W-BYTE_W){1'b0}}, byte_len_i[b]} : '0);
    assign hit_lo = clr_vld_i && (int'(clr_word_i) == WL);
    assign hit_hi = clr_vld_i && (int'(clr_word_i) == WL + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_cnt_o[b] <= '0;
      end else begin
        byte_cnt_o[b][CNT_W-1:0]       <= hit_lo ? '0 : sum[CNT_W-1:0];
        byte_cnt_o[b][2*CNT_W-1:CNT_W] <= hit_hi ? '0 : sum[2*CNT_W-1:CNT_W];
      end
    end
  end
endmodule

// File: rtl/stat_flush_seq.sv
module stat_flush_seq
  import stat_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [PORT_W-1:0] clr_port_o,
  output logic [WIDX_W-1:0] clr_word_o
);
  localparam logic [PORT_W-1:0] LAST_P = PORT_W'(NUM_PORTS - 1);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      clr_port_o <= '0;
      clr_word_o <= '0;
    end else if (!busy_o) begin
      busy_o     <= start_i;
      clr_port_o <= '0;
      clr_word_o <= '0;
    end else if (clr_word_o == LAST_W) begin
      clr_word_o <= '0;
      if (clr_port_o == LAST_P) begin
        busy_o     <= 1'b0;
        clr_port_o <= '0;
      end else begin
        clr_port_o <= clr_port_o + 1'b1;
      end
    end else begin
      clr_word_o <= clr_word_o + 1'b1;
    end
  end
endmodule

// File: rtl/stat_rd_mux.sv
module stat_rd_mux
  import stat_pkg::*;
#(
  parameter int          NUM_PORTS = 7,
  parameter logic [15:0] WIN_BASE  = 16'h1000,
  parameter logic [15:0] CTRL_ADDR = 16'h0030,
  parameter logic [15:0] EN_ADDR   = 16'h0034,
  parameter int          BUSY_BIT  = 31
) (
  input  logic [15:0]                                    rd_addr_i,
  input  logic [NUM_PORTS-1:0][NUM_EVT-1:0][CNT_W-1:0]   evt_cnt_i,
  input  logic [NUM_PORTS-1:0][NUM_BYTE-1:0][2*CNT_W-1:0] byte_cnt_i,
  input  logic                                           busy_i,
  input  logic                                           en_i,
  output logic [CNT_W-1:0]                               rd_word_o
);
  logic [15:0] off;
  logic [5:0]  w;
  logic        in_win;

  assign off    = rd_addr_i - WIN_BASE;
  assign w      = off[7:2];
  assign in_win = (rd_addr_i >= WIN_BASE) && (int'(off[15:8]) < NUM_PORTS);

  always_comb begin
    rd_word_o = '0;
    if (in_win) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(off[15:8]) == p) begin
          for (int e = 0; e < NUM_EVT; e++)
            if (int'(w) == evt_word(e)) rd_word_o = evt_cnt_i[p][e];
          for (int b = 0; b < NUM_BYTE; b++) begin
            if (int'(w) == byte_lo(b))     rd_word_o = byte_cnt_i[p][b][CNT_W-1:0];
            if (int'(w) == byte_lo(b) + 1) rd_word_o = byte_cnt_i[p][b][2*CNT_W-1:CNT_W];
          end
        end
      end
    end else if (rd_addr_i[15:2] == CTRL_ADDR[15:2]) begin
      rd_word_o[BUSY_BIT] = busy_i;
    end else if (rd_addr_i[15:2] == EN_ADDR[15:2]) begin
      rd_word_o[0] = en_i;
    end
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_pkg::*;
#(
  parameter int          NUM_PORTS = 7,
  parameter int          BYTE_W    = 16,
  parameter logic [15:0] WIN_BASE  = 16'h1000,
  parameter logic [15:0] CTRL_ADDR = 16'h0030,
  parameter logic [15:0] EN_ADDR   = 16'h0034,
  parameter int          BUSY_BIT  = 31,
  parameter int          FLUSH_BIT = 24,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS*NUM_EVT-1:0]  evt_i,
  input  logic [NUM_PORTS-1:0]          rx_byte_vld_i,
  input  logic [NUM_PORTS-1:0]          rx_byte_bad_i,
  input  logic [NUM_PORTS*BYTE_W-1:0]   rx_byte_len_i,
  input  logic [NUM_PORTS-1:0]          tx_byte_vld_i,
  input  logic [NUM_PORTS*BYTE_W-1:0]   tx_byte_len_i,
  input  logic                          wr_en_i,
  input  logic [15:0]                   wr_addr_i,
  input  logic [31:0]                   wr_data_i,
  input  logic                          rd_en_i,
  input  logic [15:0]                   rd_addr_i,
  output logic [31:0]                   rd_data_o
);
  logic                                            en_q;
  logic                                            busy;
  logic                                            start;
  logic [PORT_W-1:0]                               clr_port;
  logic [WIDX_W-1:0]                               clr_word;
  logic [NUM_PORTS-1:0][NUM_EVT-1:0][CNT_W-1:0]    evt_cnt;
  logic [NUM_PORTS-1:0][NUM_BYTE-1:0][2*CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0]                                rd_word;

  assign start = wr_en_i && (wr_addr_i[15:2] == CTRL_ADDR[15:2]) &&
                 wr_data_i[BUSY_BIT] && wr_data_i[FLUSH_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                               en_q <= 1'b0;
    else if (wr_en_i && (wr_addr_i[15:2] == EN_ADDR[15:2]))    en_q <= wr_data_i[0];
  end

  stat_flush_seq #(.NUM_PORTS(NUM_PORTS)) u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .busy_o     (busy),
    .clr_port_o (clr_port),
    .clr_word_o (clr_word)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_BYTE-1:0]             bvld;
    logic [NUM_BYTE-1:0][BYTE_W-1:0] blen;
    logic                            pclr;
    assign bvld[0] = rx_byte_vld_i[p] && !rx_byte_bad_i[p];
    assign bvld[1] = rx_byte_vld_i[p] &&  rx_byte_bad_i[p];
    assign bvld[2] = tx_byte_vld_i[p];
    assign blen[0] = rx_byte_len_i[p*BYTE_W +: BYTE_W];
    assign blen[1] = rx_byte_len_i[p*BYTE_W +: BYTE_W];
    assign blen[2] = tx_byte_len_i[p*BYTE_W +: BYTE_W];
    assign pclr    = busy && (clr_port == PORT_W'(p));

    stat_port_bank #(.BYTE_W(BYTE_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_q),
      .evt_i      (evt_i[p*NUM_EVT +: NUM_EVT]),
      .byte_vld_i (bvld),
      .byte_len_i (blen),
      .clr_vld_i  (pclr),
      .clr_word_i (clr_word),
      .evt_cnt_o  (evt_cnt[p]),
      .byte_cnt_o (byte_cnt[p])
    );
  end

  stat_rd_mux #(
    .NUM_PORTS (NUM_PORTS),
    .WIN_BASE  (WIN_BASE),
    .CTRL_ADDR (CTRL_ADDR),
    .EN_ADDR   (EN_ADDR),
    .BUSY_BIT  (BUSY_BIT)
  ) u_rd (
    .rd_addr_i  (rd_addr_i),
    .evt_cnt_i  (evt_cnt),
    .byte_cnt_i (byte_cnt),
    .busy_i     (busy),
    .en_i       (en_q),
    .rd_word_o  (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_word;
  end
endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk
  import stat_pkg::*;
#(
  parameter int          NUM_PORTS = 7,
  parameter logic [15:0] WIN_BASE  = 16'h1000,
  parameter logic [15:0] CTRL_ADDR = 16'h0030,
  parameter int          BUSY_BIT  = 31,
  parameter int          FLUSH_BIT = 24,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [15:0]       wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [15:0]       rd_addr_i,
  input logic [31:0]       rd_data_o,
  input logic              evt0_i,
  input logic              en_i,
  input logic              busy_i,
  input logic [PORT_W-1:0] clr_port_i,
  input logic [WIDX_W-1:0] clr_word_i,
  input logic [CNT_W-1:0]  cnt00_i
);
  logic        go, last, hit00, unmapped;
  logic [15:0] off;

  assign go       = wr_en_i && (wr_addr_i[15:2] == CTRL_ADDR[15:2]) &&
                    wr_data_i[BUSY_BIT] && wr_data_i[FLUSH_BIT];
  assign last     = (int'(clr_port_i) == NUM_PORTS - 1) && (int'(clr_word_i) == WORDS - 1);
  assign hit00    = busy_i && (clr_port_i == '0) && (clr_word_i == '0);
  assign off      = rd_addr_i - WIN_BASE;
  assign unmapped = rd_en_i && (rd_addr_i >= WIN_BASE) &&
                    (int'(off[15:8]) < NUM_PORTS) && (int'(off[7:2]) >= WORDS);

  a_r7_flush_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !busy_i |=> busy_i);
  a_r7_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !go |=> !busy_i);
  a_r8_walk_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !last |=> busy_i);
  a_r8_walk_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && last |=> !busy_i);
  a_r8_walk_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (clr_port_i == '0) && (clr_word_i == '0));
  a_r9_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit00 |=> cnt00_i == '0);
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && evt0_i && !hit00 |=> cnt00_i == $past(cnt00_i) + 1'b1);
  a_r6_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !hit00 |=> $stable(cnt00_i));
  a_r10_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |=> rd_data_o == '0);
endmodule

bind stat_counter_bank stat_counter_bank_chk #(
  .NUM_PORTS (NUM_PORTS),
  .WIN_BASE  (WIN_BASE),
  .CTRL_ADDR (CTRL_ADDR),
  .BUSY_BIT  (BUSY_BIT),
  .FLUSH_BIT (FLUSH_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .evt0_i     (evt_i[0]),
  .en_i       (en_q),
  .busy_i     (busy),
  .clr_port_i (clr_port),
  .clr_word_i (clr_word),
  .cnt00_i    (evt_cnt[0][0])
);

// File: tb/stat_counter_bank_bench.sv
module stat_counter_bank_bench;
  localparam int NP    = 7;
  localparam int NE    = 36;
  localparam int BW    = 16;
  localparam int NWORD = 42;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NP*NE-1:0]  evt_i = '0;
  logic [NP-1:0]     rx_byte_vld_i = '0, rx_byte_bad_i = '0, tx_byte_vld_i = '0;
  logic [NP*BW-1:0]  rx_byte_len_i = '0, tx_byte_len_i = '0;
  logic              wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0]       wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0]       wr_data_i = '0;
  logic [31:0]       rd_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  stat_counter_bank u_stat_counter_bank (
    .clk_i, .rst_ni, .evt_i, .rx_byte_vld_i, .rx_byte_bad_i, .rx_byte_len_i,
    .tx_byte_vld_i, .tx_byte_len_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i, .rd_addr_i, .rd_data_o
  );

  function automatic logic [15:0] cadr(input int p, input int w);
    return 16'(16'h1000 + 16'h100 * p + 4 * w);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_evt(input int p, input int e, input int n);
    evt_i[p*NE+e] = 1'b1;
    repeat (n) @(negedge clk_i);
    evt_i[p*NE+e] = 1'b0;
  endtask

  // kind 0 rx good, 1 rx bad, 2 tx
  task automatic pulse_bytes(input int p, input int kind, input int len, input int n);
    if (kind == 2) begin
      tx_byte_vld_i[p] = 1'b1; tx_byte_len_i[p*BW +: BW] = BW'(len);
    end else begin
      rx_byte_vld_i[p] = 1'b1; rx_byte_bad_i[p] = (kind == 1);
      rx_byte_len_i[p*BW +: BW] = BW'(len);
    end
    repeat (n) @(negedge clk_i);
    tx_byte_vld_i[p] = 1'b0; rx_byte_vld_i[p] = 1'b0; rx_byte_bad_i[p] = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 port0 word0", cadr(0, 0), 0);
    rd_chk("R1 port6 word41", cadr(6, 41), 0);
    rd_chk("R1 busy", 16'h0030, 0);
    rd_chk("R1 enable", 16'h0034, 0);
  endtask

  task automatic t_disabled;
    pulse_evt(1, 3, 5);
    pulse_bytes(1, 2, 100, 2);
    rd_chk("R6 event ignored", cadr(1, 3), 0);
    rd_chk("R6 bytes ignored", cadr(1, 33), 0);
  endtask

  task automatic t_events;
    wr(16'h0034, 32'h1);
    rd_chk("R1 enable set", 16'h0034, 32'h1);
    pulse_evt(2, 0, 3);
    rd_chk("R3 port2 evt0", cadr(2, 0), 3);
    pulse_evt(2, 16, 2);
    rd_chk("R2 port2 evt16 at 0x50", 16'h1250, 2);
    pulse_evt(6, 29, 5);
    rd_chk("R2 port6 evt29 at 0x8C", 16'h168C, 5);
    pulse_evt(6, 35, 1);
    rd_chk("R2 port6 evt35 at 0xA4", 16'h16A4, 1);
    rd_chk("R3 port3 untouched", cadr(3, 0), 0);
    evt_i[3*NE+17] = 1'b1; evt_i[5*NE+17] = 1'b1;
    repeat (4) @(negedge clk_i);
    evt_i = '0;
    rd_chk("R3 simultaneous port3", 16'h1354, 4);
    rd_chk("R3 simultaneous port5", 16'h1554, 4);
  endtask

  task automatic t_bytes;
    pulse_bytes(1, 0, 100, 1);
    pulse_bytes(1, 0, 200, 1);
    rd_chk("R4 rx good low", 16'h113C, 300);
    rd_chk("R4 rx good high", 16'h1140, 0);
    pulse_bytes(1, 1, 64, 1);
    rd_chk("R4 rx bad low", 16'h1144, 64);
    rd_chk("R4 rx good unchanged by bad", 16'h113C, 300);
    pulse_bytes(1, 2, 1500, 1);
    rd_chk("R4 tx low", 16'h1184, 1500);
  endtask

  task automatic t_carry;
    pulse_bytes(4, 2, 16'hFFFF, 65538);
    rd_chk("R5 tx low after carry", 16'h1484, 32'h0000FFFE);
    rd_chk("R5 tx high after carry", 16'h1488, 32'h1);
  endtask

  task automatic t_unmapped;
    rd_chk("R10 offset 0xA8", 16'h10A8, 0);
    rd_chk("R10 offset 0xAC", 16'h16AC, 0);
    rd_chk("R10 offset 0xF0", 16'h12F0, 0);
    rd_chk("R10 port 7 window", 16'h1700, 0);
  endtask

  task automatic t_flush_only;
    wr(16'h0030, 32'h0100_0000);
    rd_chk("R7 flush bit alone no busy", 16'h0030, 0);
    rd_chk("R7 counters kept", cadr(2, 0), 3);
  endtask

  task automatic t_flush;
    int cnt = 0;
    wr(16'h0030, 32'h8100_0000);
    rd_en_i = 1'b1; rd_addr_i = 16'h0030;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (rd_data_o[31]) cnt++;
      else break;
    end
    rd_en_i = 1'b0;
    chk("R8 busy cycles", 32'(cnt), 32'(NP * NWORD));
    rd_chk("R8 busy clear", 16'h0030, 0);
    rd_chk("R8 port2 evt0 cleared", cadr(2, 0), 0);
    rd_chk("R8 port4 tx high cleared", 16'h1488, 0);
    rd_chk("R8 port6 evt35 cleared", 16'h16A4, 0);
  endtask

  task automatic t_flush_wins;
    wr(16'h0030, 32'h8100_0000);
    pulse_evt(0, 0, NP * NWORD);
    repeat (4) @(negedge clk_i);
    rd_chk("R9 flush wins on collision", cadr(0, 0), 32'(NP * NWORD - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_disabled();
    t_events();
    t_bytes();
    t_unmapped();
    t_flush_only();
    t_carry();
    t_flush();
    t_flush_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule